// File: doc/BRIEF.md
# Control/Status Register Set/Clear Unit with Floating-Point State Tracking

This block carries out the bit-set and bit-clear forms of control/status register (CSR) instructions against a small register file. Each operation reads the addressed CSR and returns its prior value to the destination register. The prior value is sign-extended from the CSR width to the register width. The unit then writes back the old value with the operand's bits set or cleared. The operand is either a register value or a 5-bit immediate taken from the source-index field. When that field is zero, no write is made, and the operation is checked for permission as a plain read.

The file holds three CSRs. The first is a 5-bit floating-point exception-flags register. The second is a status register that carries a 2-bit floating-point context-state field and a summary bit. The third is a constant identification register. Any address whose two top bits are both one is read-only.

A side port from the floating-point datapath reports each issued FP operation together with the exception flags it raised. Those flags are OR-merged into the flags register. The context state becomes dirty only when the reported flag vector is nonzero. An FP operation issued while the context state is off is flagged as illegal.

Top module: `csr_rmw_unit`

## Requirements
- R1: A set operation (`op_kind`=0) with a nonzero source index writes old | operand into the addressed CSR.
- R2: A clear operation (`op_kind`=1) with a nonzero source index writes old & ~operand into the addressed CSR.
- R3: When `op_imm`=1, the operand is `src_idx` zero-extended. When `op_imm`=0, the operand is `rs1_val` truncated to the CSR width.
- R4: When `src_idx` is zero, no CSR changes and `csr_illegal` stays low, whatever the value of `rs1_val`.
- R5: A valid operation with a nonzero `src_idx` to an address with bits [11:10]=2'b11 raises `csr_illegal` in the same cycle and changes no state. With a zero `src_idx`, such an address reads normally and raises no fault.
- R6: In the cycle of the operation, `rd_val` is the CSR's value before the operation, sign-extended from bit CSR_W-1. Unmapped addresses read zero. The identification register (address 0xF14) reads the parameter ID_VALUE.
- R7: The flags register (address 0x001) reads as 5 bits zero-extended. Writes to it keep only bits [4:0].
- R8: An FP operation (`fp_valid`) issued while the context state is not off ORs `fp_flags` into the flags register. The context state becomes dirty (3) on the next edge only if `fp_flags` is nonzero. Otherwise it is unchanged.
- R9: `fp_illegal` is high exactly when `fp_valid` is high and the context state is off (0). Such an operation leaves the flags unchanged.
- R10: The status register (address 0x300) holds the context state in bits [14:13], encoded 0 off, 1 initial, 2 clean, 3 dirty. Its bit CSR_W-1 reads 1 exactly when the state is dirty. All other bits read 0 and ignore writes.
- R11: A write with a nonzero source index to the flags register sets the context state to dirty.
- R12: When a CSR write and an FP flag report land in the same cycle, the flags become the written value OR `fp_flags`. A nonzero `fp_flags` forces the state to dirty over any value written to the status register.
- R13: After reset, the flags register is 0 and the context state is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | A CSR set/clear operation is presented |
| op_kind | input | 1 | 0 = set bits, 1 = clear bits |
| op_imm | input | 1 | 1 = operand is the zero-extended source index |
| src_idx | input | 5 | Source register index or immediate |
| rs1_val | input | XLEN | Source register value (register form) |
| csr_addr | input | 12 | CSR address |
| fp_valid | input | 1 | An FP operation is issued this cycle |
| fp_flags | input | 5 | Exception flags raised by that FP operation |
| rd_val | output | XLEN | Prior CSR value, sign-extended |
| csr_illegal | output | 1 | Write attempted to a read-only CSR |
| fp_illegal | output | 1 | FP operation issued with the context state off |

## Verification
A CSR write and an FP flag report can fall in the same cycle. The write may target the flags register or the status register, and both paths then drive the same flag bits and context-state field. The bench provokes this directly, with a set on the flags register alongside a nonzero flag report, and with a status write that requests the clean state while the datapath reports flags. It also provokes it at random, by drawing the FP side independently of the CSR side on every cycle. Each case is judged by reading the flags and status registers back through the ports. The read values must match a bench model that applies the CSR result first and then merges the flags, with dirty taking priority.

// File: rtl/csr_rmw_pkg.sv
// Shared constants and encodings for the CSR set/clear unit.
// Assumes CSR_W >= 16 so the context-state field fits in the status word.
package csr_rmw_pkg;
    localparam int FLAG_W  = 5;    // exception-flag register width
    localparam int FS_LSB  = 13;   // low bit of the context-state field
    localparam int ADDR_W  = 12;   // CSR address width
    localparam int IDX_W   = 5;    // source-index / immediate width

    typedef enum logic [0:0] {
        RMW_SET = 1'b0,
        RMW_CLR = 1'b1
    } rmw_kind_e;

    typedef enum logic [1:0] {
        FS_OFF   = 2'd0,
        FS_INIT  = 2'd1,
        FS_CLEAN = 2'd2,
        FS_DIRTY = 2'd3
    } fs_state_e;
endpackage

// File: rtl/csr_rmw_alu.sv
// Operand select, set/clear arithmetic and write-permission decision.
// Purely combinational. Assumes the caller supplies the CSR's old value
// for the same address in the same cycle.
module csr_rmw_alu
    import csr_rmw_pkg::*;
#(
    parameter int CSR_W = 32
) (
    input  logic                  op_valid,
    input  logic                  op_kind,
    input  logic                  op_imm,
    input  logic [IDX_W-1:0]      src_idx,
    input  logic [CSR_W-1:0]      src_val,
    input  logic [ADDR_W-1:0]     csr_addr,
    input  logic [CSR_W-1:0]      old_val,
    output logic                  wr_en,
    output logic [CSR_W-1:0]      new_val,
    output logic                  ro_fault
);
    logic [CSR_W-1:0] operand;
    logic             wr_req;
    logic             addr_ro;

    // Choose immediate or register operand.
    always_comb begin
        operand = src_val;
        if (op_imm) begin
            operand = '0;
            operand[IDX_W-1:0] = src_idx;
        end
    end

    // Compute the value a write would store.
    always_comb begin
        if (op_kind == RMW_CLR) new_val = old_val & ~operand;
        else                    new_val = old_val | operand;
    end

    // A zero index turns the operation into a pure read.
    always_comb begin
        wr_req   = op_valid && (src_idx != '0);
        addr_ro  = (csr_addr[ADDR_W-1 -: 2] == 2'b11);
        ro_fault = wr_req && addr_ro;
        wr_en    = wr_req && !addr_ro;
    end
endmodule

// File: rtl/csr_rmw_file.sv
// Register file: exception flags, context state, constant identifier.
// Read is combinational. Writes and FP flag merging take effect at the
// clock edge, with the CSR result applied before the FP flags are OR-ed in.
module csr_rmw_file
    import csr_rmw_pkg::*;
#(
    parameter int                CSR_W       = 32,
    parameter logic [ADDR_W-1:0] FLAGS_ADDR  = 12'h001,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 12'h300,
    parameter logic [ADDR_W-1:0] ID_ADDR     = 12'hF14,
    parameter logic [CSR_W-1:0]  ID_VALUE    = 'h0A51
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   csr_addr,
    input  logic                wr_en,
    input  logic [CSR_W-1:0]    wr_val,
    input  logic                fp_valid,
    input  logic [FLAG_W-1:0]   fp_flags,
    output logic [CSR_W-1:0]    rd_data,
    output logic                fp_illegal,
    output logic [FLAG_W-1:0]   flags_q,
    output logic [1:0]          fs_q
);
    logic [FLAG_W-1:0] flags_d;
    logic [1:0]        fs_d;
    logic              fp_ok;
    logic              unused_wr_bits;

    assign unused_wr_bits = ^wr_val;

    // Read mux over the mapped CSRs; unmapped addresses read zero.
    always_comb begin
        rd_data = '0;
        if (csr_addr == FLAGS_ADDR) begin
            rd_data[FLAG_W-1:0] = flags_q;
        end else if (csr_addr == STATUS_ADDR) begin
            rd_data[FS_LSB +: 2] = fs_q;
            rd_data[CSR_W-1]     = (fs_q == FS_DIRTY);
        end else if (csr_addr == ID_ADDR) begin
            rd_data = ID_VALUE;
        end
    end

    // Next state: CSR write first, then FP flag accumulation.
    always_comb begin
        fp_ok      = fp_valid && (fs_q != FS_OFF);
        fp_illegal = fp_valid && (fs_q == FS_OFF);
        flags_d    = flags_q;
        fs_d       = fs_q;
        if (wr_en) begin
            if (csr_addr == FLAGS_ADDR) begin
                flags_d = wr_val[FLAG_W-1:0];
                fs_d    = FS_DIRTY;
            end else if (csr_addr == STATUS_ADDR) begin
                fs_d = wr_val[FS_LSB +: 2];
            end
        end
        if (fp_ok) begin
            flags_d = flags_d | fp_flags;
            if (fp_flags != '0) fs_d = FS_DIRTY;
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            fs_q    <= FS_OFF;
        end else begin
            flags_q <= flags_d;
            fs_q    <= fs_d;
        end
    end
endmodule

// File: rtl/csr_rmw_unit.sv
// Top of the CSR set/clear unit. Returns the old CSR value sign-extended
// to XLEN in the same cycle and commits the update at the next edge.
// Assumes XLEN >= CSR_W and CSR_W >= 16.
module csr_rmw_unit
    import csr_rmw_pkg::*;
#(
    parameter int                XLEN        = 64,
    parameter int                CSR_W       = 32,
    parameter logic [ADDR_W-1:0] FLAGS_ADDR  = 12'h001,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 12'h300,
    parameter logic [ADDR_W-1:0] ID_ADDR     = 12'hF14,
    parameter logic [CSR_W-1:0]  ID_VALUE    = 'h0A51
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic               op_kind,
    input  logic               op_imm,
    input  logic [IDX_W-1:0]   src_idx,
    input  logic [XLEN-1:0]    rs1_val,
    input  logic [ADDR_W-1:0]  csr_addr,
    input  logic               fp_valid,
    input  logic [FLAG_W-1:0]  fp_flags,
    output logic [XLEN-1:0]    rd_val,
    output logic               csr_illegal,
    output logic               fp_illegal
);
    localparam int EXT_W = XLEN - CSR_W;

    logic [CSR_W-1:0]  old_val;
    logic [CSR_W-1:0]  new_val;
    logic              wr_en;
    logic [FLAG_W-1:0] flags_w;
    logic [1:0]        fs_w;
    logic              unused_src_bits;

    assign unused_src_bits = ^rs1_val;

    csr_rmw_alu #(.CSR_W(CSR_W)) alu_i (
        .op_valid (op_valid),
        .op_kind  (op_kind),
        .op_imm   (op_imm),
        .src_idx  (src_idx),
        .src_val  (rs1_val[CSR_W-1:0]),
        .csr_addr (csr_addr),
        .old_val  (old_val),
        .wr_en    (wr_en),
        .new_val  (new_val),
        .ro_fault (csr_illegal)
    );

    csr_rmw_file #(
        .CSR_W       (CSR_W),
        .FLAGS_ADDR  (FLAGS_ADDR),
        .STATUS_ADDR (STATUS_ADDR),
        .ID_ADDR     (ID_ADDR),
        .ID_VALUE    (ID_VALUE)
    ) file_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .csr_addr   (csr_addr),
        .wr_en      (wr_en),
        .wr_val     (new_val),
        .fp_valid   (fp_valid),
        .fp_flags   (fp_flags),
        .rd_data    (old_val),
        .fp_illegal (fp_illegal),
        .flags_q    (flags_w),
        .fs_q       (fs_w)
    );

    // Sign-extend the old value to the register width.
    generate
        if (EXT_W > 0) begin : g_sext
            assign rd_val = {{EXT_W{old_val[CSR_W-1]}}, old_val};
        end else begin : g_same
            assign rd_val = old_val;
        end
    endgenerate
endmodule

// File: rtl/csr_rmw_unit_chk.sv
// Property checker for csr_rmw_unit, attached with bind below.
module csr_rmw_unit_chk #(
    parameter int          CSR_W       = 32,
    parameter logic [11:0] STATUS_ADDR = 12'h300
) (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic [4:0]  src_idx,
    input logic [11:0] csr_addr,
    input logic        fp_valid,
    input logic [4:0]  fp_flags,
    input logic        rd_sign_hi,
    input logic        rd_sign_lo,
    input logic        csr_illegal,
    input logic        fp_illegal,
    input logic [4:0]  flags_q,
    input logic [1:0]  fs_q
);
    p_ro_write_illegal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && src_idx != 5'd0 && csr_addr[11:10] == 2'b11) |-> csr_illegal);

    p_ro_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_illegal && !fp_valid) |=> ($stable(flags_q) && $stable(fs_q)));

    p_zero_idx_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && src_idx == 5'd0) |-> !csr_illegal);

    p_zero_idx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && src_idx == 5'd0 && !fp_valid) |=> ($stable(flags_q) && $stable(fs_q)));

    p_fp_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_valid && fs_q == 2'd0) |-> fp_illegal);

    p_fp_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !fp_valid |-> !fp_illegal);

    p_accum_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_valid && !fp_illegal) |=> ((flags_q & $past(fp_flags)) == $past(fp_flags)));

    p_dirty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_valid && !fp_illegal && fp_flags != 5'd0) |=> (fs_q == 2'd3));

    p_summary_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && csr_addr == STATUS_ADDR) |-> (rd_sign_lo == (fs_q == 2'd3)));

    p_sext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> (rd_sign_hi == rd_sign_lo));
endmodule

bind csr_rmw_unit csr_rmw_unit_chk #(
    .CSR_W       (CSR_W),
    .STATUS_ADDR (STATUS_ADDR)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .src_idx     (src_idx),
    .csr_addr    (csr_addr),
    .fp_valid    (fp_valid),
    .fp_flags    (fp_flags),
    .rd_sign_hi  (rd_val[XLEN-1]),
    .rd_sign_lo  (rd_val[CSR_W-1]),
    .csr_illegal (csr_illegal),
    .fp_illegal  (fp_illegal),
    .flags_q     (flags_w),
    .fs_q        (fs_w)
);

// File: tb/csr_rmw_unit_tb_top.sv
module csr_rmw_unit_tb_top;
    localparam int          XLEN  = 64;
    localparam int          CSR_W = 32;
    localparam logic [11:0] A_FLG = 12'h001;
    localparam logic [11:0] A_STS = 12'h300;
    localparam logic [11:0] A_ID  = 12'hF14;
    localparam logic [11:0] A_OTH = 12'h7C0;
    localparam logic [11:0] A_RO0 = 12'hC05;
    localparam logic [31:0] IDV   = 32'h0000_0A51;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             op_valid = 1'b0, op_kind = 1'b0, op_imm = 1'b0;
    logic [4:0]       src_idx = '0;
    logic [XLEN-1:0]  rs1_val = '0;
    logic [11:0]      csr_addr = '0;
    logic             fp_valid = 1'b0;
    logic [4:0]       fp_flags = '0;
    logic [XLEN-1:0]  rd_val;
    logic             csr_illegal, fp_illegal;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [4:0] m_flags;
    logic [1:0] m_fs;

    always #5 clk = ~clk;

    csr_rmw_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_imm(op_imm), .src_idx(src_idx), .rs1_val(rs1_val),
        .csr_addr(csr_addr), .fp_valid(fp_valid), .fp_flags(fp_flags),
        .rd_val(rd_val), .csr_illegal(csr_illegal), .fp_illegal(fp_illegal)
    );

    function automatic logic [31:0] model_read(input logic [11:0] a);
        if (a == A_FLG) return {27'd0, m_flags};
        if (a == A_STS) return {(m_fs == 2'd3), 16'd0, m_fs, 13'd0};
        if (a == A_ID)  return IDV;
        return 32'd0;
    endfunction

    function automatic logic [63:0] sext(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // One operation: drive, check same-cycle outputs, advance the model.
    task automatic do_op(input string req, input logic kind, input logic imm,
                         input logic [4:0] idx, input logic [63:0] val,
                         input logic [11:0] a, input logic fpv, input logic [4:0] fpf);
        logic [31:0] old, opnd, nv;
        logic [4:0]  nf;
        logic [1:0]  nfs;
        logic        wreq, ro;
        @(negedge clk);
        op_valid = 1'b1; op_kind = kind; op_imm = imm; src_idx = idx;
        rs1_val = val; csr_addr = a; fp_valid = fpv; fp_flags = fpf;
        #1;
        old  = model_read(a);
        wreq = (idx != 5'd0);
        ro   = (a[11:10] == 2'b11);
        chk({req, " rd_val"}, rd_val, sext(old));
        chk({req, " csr_illegal"}, {63'd0, csr_illegal}, {63'd0, wreq && ro});
        chk({req, " fp_illegal"}, {63'd0, fp_illegal}, {63'd0, fpv && m_fs == 2'd0});
        opnd = imm ? {27'd0, idx} : val[31:0];
        nv   = kind ? (old & ~opnd) : (old | opnd);
        nf   = m_flags;
        nfs  = m_fs;
        if (wreq && !ro) begin
            if (a == A_FLG) begin nf = nv[4:0]; nfs = 2'd3; end
            else if (a == A_STS) nfs = nv[14:13];
        end
        if (fpv && m_fs != 2'd0) begin
            nf = nf | fpf;
            if (fpf != 5'd0) nfs = 2'd3;
        end
        @(posedge clk);
        m_flags = nf;
        m_fs    = nfs;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h0000_5EED));
        m_flags = '0;
        m_fs    = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R13: reset state, read with zero index.
        do_op("R13", 1'b0, 1'b0, 5'd0, 64'hFFFF, A_FLG, 1'b0, 5'd0);
        do_op("R13", 1'b0, 1'b0, 5'd0, 64'hFFFF, A_STS, 1'b0, 5'd0);
        // R9: FP op with state off is illegal and does not merge flags.
        do_op("R9", 1'b0, 1'b0, 5'd0, 64'd0, A_OTH, 1'b1, 5'h1F);
        do_op("R9", 1'b0, 1'b0, 5'd0, 64'd0, A_FLG, 1'b0, 5'd0);
        // R1: register-form set of FS=clean.
        do_op("R1", 1'b0, 1'b0, 5'd1, 64'h4000, A_STS, 1'b0, 5'd0);
        do_op("R1", 1'b0, 1'b0, 5'd0, 64'd0, A_STS, 1'b0, 5'd0);
        // R8: zero flag report keeps state clean, nonzero makes it dirty.
        do_op("R8", 1'b0, 1'b0, 5'd0, 64'd0, A_OTH, 1'b1, 5'd0);
        do_op("R8", 1'b0, 1'b0, 5'd0, 64'd0, A_STS, 1'b1, 5'h05);
        // R6, R10: dirty status sign-extends from bit 31.
        @(negedge clk);
        op_valid = 1'b1; op_imm = 1'b0; src_idx = 5'd0; csr_addr = A_STS; fp_valid = 1'b0;
        #1 chk("R6 R10 status sext", rd_val, 64'hFFFF_FFFF_8000_6000);
        do_op("R8", 1'b0, 1'b0, 5'd0, 64'd0, A_FLG, 1'b0, 5'd0);
        // R2, R3: immediate clear of bit 0.
        do_op("R2 R3", 1'b1, 1'b1, 5'd1, 64'hFFFF, A_FLG, 1'b0, 5'd0);
        // R7: register set with upper bits ignored.
        do_op("R7", 1'b0, 1'b0, 5'd7, 64'hFFFF_FFFF_FFFF_FFE2, A_FLG, 1'b0, 5'd0);
        do_op("R7", 1'b0, 1'b0, 5'd0, 64'd0, A_FLG, 1'b0, 5'd0);
        // R11: turn state off, then flag write makes it dirty.
        do_op("R11", 1'b1, 1'b0, 5'd3, 64'h6000, A_STS, 1'b0, 5'd0);
        do_op("R11", 1'b0, 1'b1, 5'd2, 64'd0, A_FLG, 1'b0, 5'd0);
        do_op("R11", 1'b0, 1'b0, 5'd0, 64'd0, A_STS, 1'b0, 5'd0);
        // R5: read-only address, zero index vs nonzero index with zero value.
        do_op("R5", 1'b0, 1'b0, 5'd0, 64'hFF, A_ID, 1'b0, 5'd0);
        do_op("R5", 1'b0, 1'b0, 5'd5, 64'd0, A_ID, 1'b0, 5'd0);
        do_op("R5", 1'b1, 1'b1, 5'd9, 64'd0, A_RO0, 1'b0, 5'd0);
        // R4: zero index with all-ones register value changes nothing.
        do_op("R4", 1'b1, 1'b0, 5'd0, '1, A_FLG, 1'b0, 5'd0);
        do_op("R4", 1'b1, 1'b0, 5'd0, '1, A_STS, 1'b0, 5'd0);
        do_op("R4", 1'b0, 1'b0, 5'd0, 64'd0, A_FLG, 1'b0, 5'd0);
        // R12: same-cycle flag write and FP report; status write loses to dirty.
        do_op("R12", 1'b0, 1'b1, 5'h08, 64'd0, A_FLG, 1'b1, 5'h10);
        do_op("R12", 1'b0, 1'b0, 5'd0, 64'd0, A_FLG, 1'b0, 5'd0);
        do_op("R12", 1'b1, 1'b0, 5'd4, 64'h2000, A_STS, 1'b1, 5'h01);
        do_op("R12", 1'b0, 1'b0, 5'd0, 64'd0, A_STS, 1'b0, 5'd0);

        // Constrained random mix over all addresses and both sides.
        for (int i = 0; i < 600; i++) begin
            logic [11:0] a;
            logic [4:0]  idx, fpf;
            logic [63:0] val;
            case ($urandom % 5)
                0: a = A_FLG;
                1: a = A_STS;
                2: a = A_ID;
                3: a = A_RO0;
                default: a = A_OTH;
            endcase
            idx = (($urandom % 4) == 0) ? 5'd0 : 5'($urandom);
            val = {32'($urandom), 32'($urandom)};
            fpf = (($urandom % 2) == 0) ? 5'd0 : 5'($urandom);
            do_op("R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12 random", 1'($urandom),
                  1'($urandom), idx, val, a, 1'($urandom), fpf);
        end
        finish_run();
    end
endmodule